// File: doc/BRIEF.md
# Slow-Peripheral Cycle Stretch Controller

This block paces a 2 MHz processor bus from a faster system clock. A single free-running divider splits system-clock time into 2 MHz slots and pairs those slots into a 1 MHz peripheral period. The block drives `cpuEn`, a one-clock pulse that lets the processor end its current bus cycle. When the address of a cycle falls in one of the slow I/O regions, the block holds back that pulse. The cycle then stays open until it can finish together with the 1 MHz peripheral enable.

The length of a stretched cycle is not fixed. It is two slots when the cycle begins in the first half of a 1 MHz period, and three slots when it begins in the second half. Because every stretched cycle ends on a 1 MHz period boundary, a slow access that follows directly always costs two slots. Each bus cycle is decoded on its own, so both slow cycles of a read-modify-write are stretched.

A mode input makes the top four bytes of the 0xFC page run at full speed.

Top module: `cycle_stretch`

## Requirements
- R1: A cycle whose address is in 0x0000–0xFBFF, 0xFE19–0xFE3F, 0xFE80–0xFEBF or 0xFEE0–0xFFFF lasts one slot (DIV system clocks) with no stretch.
- R2: A cycle whose address is in 0xFC00–0xFDFF, 0xFE00–0xFE18, 0xFE40–0xFE7F or 0xFEC0–0xFEDF is stretched.
- R3: Slots are numbered from reset, starting with slot 0 as even. A stretched cycle lasts 2 slots if it starts in an even slot and 3 slots if it starts in an odd slot.
- R4: A stretched cycle ends in the same clock as a `periphEn` pulse, so the next cycle starts in an even slot and a back-to-back slow cycle lasts 2 slots.
- R5: `periphEn` pulses for one clock at the last clock of every odd slot. The first pulse is at clock 2·DIV−1 after reset is released.
- R6: With `fastCart` high, 0xFCFC–0xFCFF is handled as in R1. With `fastCart` low, that range is handled as in R2.
- R7: The slow/fast decision is taken at the first clock of a cycle. Changes to `busAddr`, `busValid` or `fastCart` later in the same cycle have no effect on its length.
- R8: `cpuEn` pulses exactly once per cycle, on its last clock. `stretchActive` is high for exactly (slots−1)·DIV clocks of each cycle.
- R9: A cycle with `busValid` low is handled as in R1, whatever the address.
- R10: While `rst` is high, `cpuEn`, `periphEn`, `slowSel` and `stretchActive` are low.
- R11: `slowSel` reports the decision of the current cycle on every clock of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, DIV clocks per 2 MHz slot |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 16 | Processor address of the current cycle |
| busValid | input | 1 | Current cycle is a real bus access |
| fastCart | input | 1 | Run 0xFCFC–0xFCFF at full speed |
| cpuEn | output | 1 | Processor cycle-advance pulse |
| periphEn | output | 1 | 1 MHz peripheral enable pulse |
| slowSel | output | 1 | Current cycle is a slow access |
| stretchActive | output | 1 | Current clock belongs to an added slot |

## Verification
The assertions assume that `busAddr`, `busValid` and `fastCart` are settled at the first clock of every cycle, which is the clock right after a `cpuEn` pulse. They also assume DIV is at least 2, so that a slot start and a slot end never fall on the same clock. The stimulus changes the bus inputs only on the falling edge where `cpuEn` is seen high, or two clocks into a cycle. The second case deliberately moves them to the opposite kind of region or mode, to show that the decision already taken is kept. The reference model tracks slot parity itself from the lengths it predicts, so the two- and three-slot cases both follow from the order of the vectors.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;

  function automatic logic isSlowAddr(input logic [15:0] addr, input logic fastCartEn);
    logic [7:0] low;
    logic slow;
    low = addr[7:0];
    case (addr[15:8])
      8'hFC:   slow = !(fastCartEn && (low[7:2] == 6'b111111));
      8'hFD:   slow = 1'b1;
      8'hFE:   slow = (low <= 8'h18) || (low[7:6] == 2'b01) || (low[7:5] == 3'b110);
      default: slow = 1'b0;
    endcase
    return slow;
  endfunction

endpackage

// File: rtl/stretch_datapath.sv
module stretch_datapath
  import stretch_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [15:0]  busAddr,
  input  logic         busValid,
  input  logic         fastCart,
  input  ctrlStrobes_t strobes,
  output logic         fastTick,
  output logic         slotStart,
  output logic         phaseOdd,
  output logic         slowNow,
  output logic         slowHeld,
  output logic         periphEn
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] divCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCount <= '0;
      phaseOdd <= 1'b0;
    end else if (fastTick) begin
      divCount <= '0;
      phaseOdd <= ~phaseOdd;
    end else begin
      divCount <= divCount + 1'b1;
    end
  end

  assign fastTick  = (divCount == LAST);
  assign slotStart = (divCount == '0);
  assign periphEn  = fastTick & phaseOdd;
  assign slowNow   = busValid & isSlowAddr(busAddr, fastCart);

  always_ff @(posedge clk) begin
    if (rst)                  slowHeld <= 1'b0;
    else if (strobes.capture) slowHeld <= slowNow;
  end

  assert_phase_flips_R5: assert property (@(posedge clk) disable iff (rst)
    fastTick |=> (phaseOdd != $past(phaseOdd)));

  assert_periph_single_R5: assert property (@(posedge clk) disable iff (rst)
    periphEn |=> !periphEn);

  assert_capture_on_slot_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |-> slotStart);

endmodule

// File: rtl/stretch_control.sv
module stretch_control
  import stretch_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         fastTick,
  input  logic         slotStart,
  input  logic         phaseOdd,
  input  logic         slowNow,
  input  logic         slowHeld,
  input  logic         periphEn,
  output ctrlStrobes_t strobes,
  output logic         cpuEn,
  output logic         stretchActive,
  output logic         slowSel
);
  logic       startPend;
  logic [1:0] extraLeft;
  logic       captureNow;

  assign captureNow      = !rst & startPend & slotStart;
  assign strobes.capture = captureNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      startPend <= 1'b1;
      extraLeft <= 2'd0;
    end else if (captureNow) begin
      startPend <= 1'b0;
      extraLeft <= slowNow ? (phaseOdd ? 2'd2 : 2'd1) : 2'd0;
    end else if (fastTick) begin
      if (extraLeft != 2'd0) extraLeft <= extraLeft - 2'd1;
      else                   startPend <= 1'b1;
    end
  end

  assign cpuEn         = fastTick & (extraLeft == 2'd0) & !startPend;
  assign stretchActive = (extraLeft != 2'd0) | (captureNow & slowNow);
  assign slowSel       = captureNow ? slowNow : (slowHeld & !startPend);

  assert_slow_end_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (cpuEn && slowSel) |-> periphEn);

  assert_extra_bound_R3: assert property (@(posedge clk) disable iff (rst)
    extraLeft != 2'd3);

  assert_hold_decision_R7: assert property (@(posedge clk) disable iff (rst)
    (extraLeft != 2'd0) |=> (slowSel == $past(slowSel)));

  assert_no_advance_in_stretch_R8: assert property (@(posedge clk) disable iff (rst)
    stretchActive |-> !cpuEn);

endmodule

// File: rtl/cycle_stretch.sv
module cycle_stretch
  import stretch_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] busAddr,
  input  logic        busValid,
  input  logic        fastCart,
  output logic        cpuEn,
  output logic        periphEn,
  output logic        slowSel,
  output logic        stretchActive
);
  ctrlStrobes_t strobes;
  logic fastTick, slotStart, phaseOdd, slowNow, slowHeld;

  stretch_datapath #(.DIV(DIV)) datapath_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busValid(busValid),
    .fastCart(fastCart), .strobes(strobes), .fastTick(fastTick),
    .slotStart(slotStart), .phaseOdd(phaseOdd), .slowNow(slowNow),
    .slowHeld(slowHeld), .periphEn(periphEn)
  );

  stretch_control control_i (
    .clk(clk), .rst(rst), .fastTick(fastTick), .slotStart(slotStart),
    .phaseOdd(phaseOdd), .slowNow(slowNow), .slowHeld(slowHeld),
    .periphEn(periphEn), .strobes(strobes), .cpuEn(cpuEn),
    .stretchActive(stretchActive), .slowSel(slowSel)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |-> (!cpuEn && !periphEn && !slowSel && !stretchActive));

endmodule

// File: tb/cycle_stretch_tb_top.sv
module cycle_stretch_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] busAddr = 16'h0000;
  logic        busValid = 1'b0;
  logic        fastCart = 1'b0;
  logic        cpuEn, periphEn, slowSel, stretchActive;

  cycle_stretch #(.DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busValid(busValid),
    .fastCart(fastCart), .cpuEn(cpuEn), .periphEn(periphEn),
    .slowSel(slowSel), .stretchActive(stretchActive)
  );

  typedef struct {
    int    len;
    bit    slow;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  vecs = 0;
  int  fails = 0;
  int  benchPhase = 0;
  bit  runOn = 1'b0;
  bit  done = 1'b0;

  function automatic bit refSlow(logic [15:0] a, bit v, bit fc);
    int x;
    x = int'(a);
    if (!v) return 1'b0;
    if (x >= 'hFCFC && x <= 'hFCFF) return !fc;
    if (x >= 'hFC00 && x <= 'hFDFF) return 1'b1;
    if (x >= 'hFE00 && x <= 'hFE18) return 1'b1;
    if (x >= 'hFE40 && x <= 'hFE7F) return 1'b1;
    if (x >= 'hFEC0 && x <= 'hFEDF) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called just before the first sampling edge of a new cycle.
  task automatic busCycle(logic [15:0] a, bit v, bit fc, string tag, bit scramble);
    bit s;
    int len;
    busAddr  = a;
    busValid = v;
    fastCart = fc;
    s   = refSlow(a, v, fc);
    len = s ? ((benchPhase == 0) ? 2 : 3) : 1;
    expQ.push_back('{len, s, tag});
    benchPhase = (benchPhase + len) % 2;
    for (int n = 1; n < 100; n++) begin
      @(negedge clk);
      if (n == 3 && scramble) begin
        busAddr  = s ? 16'h0200 : 16'hFE40;
        busValid = 1'b1;
        fastCart = ~fc;
      end
      if (cpuEn) break;
    end
  endtask

  // Monitor / scoreboard
  int cnt = 0;
  int sc = 0;
  int idx = 0;
  always @(negedge clk) begin
    if (runOn && !done) begin
      bit expPe;
      cnt++;
      if (stretchActive) sc++;
      expPe = ((idx % (2 * DIV)) == (2 * DIV - 1));
      if (periphEn || expPe) check(periphEn == expPe, "R5", "periphEn at clock", idx, idx);
      idx++;
      if (cpuEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected cpuEn, queue depth", 0, 1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(cnt == e.len * DIV, e.slow ? "R3" : "R1", {e.tag, " cycle clocks"}, cnt, e.len * DIV);
          check(sc == (e.len - 1) * DIV, "R8", {e.tag, " stretch clocks"}, sc, (e.len - 1) * DIV);
          check(slowSel == e.slow, "R11", {e.tag, " slowSel"}, slowSel, e.slow);
          if (e.slow) check(periphEn == 1'b1, "R4", {e.tag, " end with periphEn"}, periphEn, 1);
        end
        cnt = 0;
        sc  = 0;
      end
    end
  end

  initial begin
    busAddr  = 16'hFE40;
    busValid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({cpuEn, periphEn, slowSel, stretchActive} == 4'b0000, "R10", "outputs in reset",
            int'({cpuEn, periphEn, slowSel, stretchActive}), 0);
    end
    @(posedge clk);
    #1;
    rst   = 1'b0;
    runOn = 1'b1;
    busCycle(16'h1234, 1, 0, "R1 ram",              0);
    busCycle(16'hFE40, 1, 0, "R2 R3 odd start",     0);
    busCycle(16'hFE4D, 1, 0, "R4 back-to-back",     0);
    busCycle(16'hFE01, 1, 0, "R4 third slow",       0);
    busCycle(16'hFE21, 1, 0, "R1 fast fe21",        0);
    busCycle(16'hFE18, 1, 0, "R2 fe18 odd",         0);
    busCycle(16'hFE19, 1, 0, "R1 fe19",             0);
    busCycle(16'hFE3F, 1, 0, "R1 fe3f",             0);
    busCycle(16'hFE7F, 1, 0, "R2 fe7f",             0);
    busCycle(16'hFE80, 1, 0, "R1 fe80",             0);
    busCycle(16'hFEBF, 1, 0, "R1 febf",             0);
    busCycle(16'hFEC0, 1, 0, "R2 fec0",             0);
    busCycle(16'hFEDF, 1, 0, "R2 fedf",             0);
    busCycle(16'hFEE0, 1, 0, "R1 fee0",             0);
    busCycle(16'hFF00, 1, 0, "R1 ff00",             0);
    busCycle(16'hFBFF, 1, 0, "R1 fbff",             0);
    busCycle(16'hFC00, 1, 0, "R2 fc00",             0);
    busCycle(16'hFDFF, 1, 0, "R2 fdff",             0);
    busCycle(16'hFCFC, 1, 1, "R6 fcfc fast mode",   0);
    busCycle(16'hFCFF, 1, 1, "R6 fcff fast mode",   0);
    busCycle(16'hFCFB, 1, 1, "R6 fcfb stays slow",  0);
    busCycle(16'hFCFC, 1, 0, "R6 fcfc slow mode",   0);
    busCycle(16'hFE40, 0, 0, "R9 invalid cycle",    0);
    busCycle(16'h0400, 1, 0, "R1 phase shift",      0);
    busCycle(16'hFE6E, 1, 0, "R3 rmw read",         0);
    busCycle(16'hFE6E, 1, 0, "R3 rmw write",        0);
    busCycle(16'hFE40, 1, 0, "R7 slow then fast",   1);
    busCycle(16'h2000, 1, 0, "R7 fast then slow",   1);
    busCycle(16'hFCFD, 1, 1, "R7 mode flip",        1);
    busCycle(16'h0000, 1, 0, "R1 tail",             0);
    @(negedge clk);
    check(expQ.size() == 0, "R8", "pending cycles at end", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vecs++;
      fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule